// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a logical address into a physical or linear address. A logical address is a choice of one of six segment registers plus an offset. Each segment register holds a 16-bit selector and a hidden descriptor cache: base, 20-bit limit, granularity bit, present bit, descriptor privilege level and default-size bit. Software-side control logic fills a register's selector and cached descriptor in one write through the load port.

In real mode the selected register's 16-bit value is shifted left by four bits and added to the low 16 bits of the offset, which gives a 20-bit address that wraps at 1 MB. No checks are made in this mode. In protected mode the address is the 32-bit cached base plus the 32-bit offset. The request is checked for presence, for privilege and for the segment limit, and the result is a fault code.

One translation request enters per cycle. The response is registered and appears one cycle later.

Top module: `seg_xlate`

## Requirements
- R1: After reset rsp_valid_o, rsp_addr_o and rsp_fault_o are 0, and all six segment registers hold selector 0 with a cleared present bit. A protected-mode request to any of them therefore reports fault code 2.
- R2: rsp_valid_o is 1 exactly in the cycle after a cycle with req_valid_i = 1. When rsp_valid_o is 0, rsp_addr_o and rsp_fault_o are 0.
- R3: In real mode (prot_mode_i = 0), rsp_addr_o[19:0] = ({selector, 4'b0000} + req_off_i[15:0]) mod 2^20. rsp_addr_o[31:20] = 0, req_off_i[31:16] is ignored, and rsp_fault_o = 0.
- R4: Different selector/offset pairs can give the same real-mode address (1100h:0450h and 1145h:0000h both give 11450h). The sum wraps at 1 MB (FFFFh:0010h gives 00000h).
- R5: In protected mode (prot_mode_i = 1) with no fault, rsp_addr_o = (base + req_off_i) mod 2^32.
- R6: Fault codes on rsp_fault_o are 0 = none, 1 = limit, 2 = not present, 3 = privilege. Whenever the code is non-zero, rsp_addr_o = 0.
- R7: req_size_i holds the access length minus one (0 to 3 for 1 to 4 bytes). With granularity 0, a limit fault (code 1) occurs when req_off_i + req_size_i exceeds the 20-bit limit.
- R8: With granularity 1, the effective limit is {limit, 12'hFFF}, and a limit fault occurs when req_off_i + req_size_i exceeds it.
- R9: With default-size bit 0, a limit fault also occurs when req_off_i + req_size_i exceeds FFFFh, whatever the limit.
- R10: A cleared present bit gives code 2, ahead of any privilege or limit fault. A request to segment index 6 or 7 in protected mode also gives code 2.
- R11: The requested privilege level is selector bits 1:0. Selector bit 2 is the table indicator (0 local, 1 global) and bits 15:3 are the index. A privilege fault (code 3) occurs when max(cpl_i, requested level) > descriptor level, and it takes priority over a limit fault.
- R12: When ld_valid_i = 1 and ld_sreg_i is 0 to 5, the selector and descriptor are written into that register. A load with ld_sreg_i = 6 or 7 changes no register. A request in the same cycle as a load to its register still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ld_valid_i | input | 1 | Load strobe |
| ld_sreg_i | input | 3 | Segment register to load |
| ld_sel_i | input | 16 | Selector value |
| ld_base_i | input | 32 | Descriptor base |
| ld_limit_i | input | 20 | Descriptor limit |
| ld_gran_i | input | 1 | Granularity: 0 bytes, 1 4 KB units |
| ld_present_i | input | 1 | Present bit |
| ld_dpl_i | input | 2 | Descriptor privilege level |
| ld_dsize_i | input | 1 | Default size: 0 16-bit, 1 32-bit |
| prot_mode_i | input | 1 | 0 real mode, 1 protected mode |
| cpl_i | input | 2 | Current privilege level |
| req_valid_i | input | 1 | Translation request strobe |
| req_sreg_i | input | 3 | Segment register of the request |
| req_off_i | input | 32 | Offset |
| req_size_i | input | 2 | Access length minus one |
| rsp_valid_o | output | 1 | Response valid |
| rsp_addr_o | output | 32 | Translated address |
| rsp_fault_o | output | 2 | Fault code |

## Verification
The hardest cases to bring about are the ones where several fault conditions hold at once, because each one needs a descriptor loaded with fields that disagree with each other. The bench loads a descriptor that is absent, has a bad privilege level and has an exceeded limit all together, then one that is present with a bad privilege level and an exceeded limit. Each request checks which code wins the priority. It also puts a load and a request to the same register in one cycle to show that the request sees the old contents. Access sizes are placed so that the end of the access lands exactly on the effective limit and one byte past it.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int unsigned NUM_SREG = 6;
  localparam int unsigned SREG_W   = 3;
  localparam int unsigned SEL_W    = 16;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned LIM_W    = 20;
  localparam int unsigned GRAN_SH  = 12;
  localparam int unsigned REAL_SH  = 4;
  localparam int unsigned REAL_AW  = SEL_W + REAL_SH;
  localparam int unsigned RM_OFF_W = 16;
  localparam int unsigned PL_W     = 2;
  localparam int unsigned SIZE_W   = 2;

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic [ADDR_W-1:0] base;
    logic [LIM_W-1:0]  limit;
    logic              gran;
    logic              present;
    logic [PL_W-1:0]   dpl;
    logic              dsize;
  } sreg_t;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_LIMIT  = 2'd1,
    FLT_ABSENT = 2'd2,
    FLT_PRIV   = 2'd3
  } fault_e;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_xlate_pkg::*;
#(
  parameter int unsigned N = NUM_SREG,
  parameter int unsigned W = SREG_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_idx_i,
  input  sreg_t        wr_data_i,
  input  logic [W-1:0] rd_idx_i,
  output sreg_t        rd_data_o,
  output logic         rd_hit_o
);
  sreg_t entry_q [N];

  for (genvar g = 0; g < N; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    entry_q[g] <= '0;
      else if (wr_en_i && (wr_idx_i == W'(g)))        entry_q[g] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    rd_hit_o  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (rd_idx_i == W'(i)) begin
        rd_data_o = entry_q[i];
        rd_hit_o  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/seg_limit_chk.sv
module seg_limit_chk
  import seg_xlate_pkg::*;
(
  input  logic [ADDR_W-1:0] off_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [LIM_W-1:0]  limit_i,
  input  logic              gran_i,
  input  logic              dsize_i,
  output logic              fault_o
);
  localparam int unsigned EW = ADDR_W + 1;
  logic [EW-1:0]     last_byte;
  logic [ADDR_W-1:0] eff_lim;

  always_comb begin
    // end offset carries into bit ADDR_W so wrap past 4 GB still faults
    last_byte = {1'b0, off_i} + EW'(size_i);
    eff_lim   = gran_i ? {limit_i, {GRAN_SH{1'b1}}} : ADDR_W'(limit_i);
    fault_o   = (last_byte > {1'b0, eff_lim}) ||
                (!dsize_i && (last_byte > EW'({RM_OFF_W{1'b1}})));
  end
endmodule

// File: rtl/seg_priv_chk.sv
module seg_priv_chk
  import seg_xlate_pkg::*;
(
  input  logic [PL_W-1:0] cpl_i,
  input  logic [PL_W-1:0] rpl_i,
  input  logic [PL_W-1:0] dpl_i,
  output logic            fault_o
);
  logic [PL_W-1:0] eff_pl;
  always_comb begin
    eff_pl  = (cpl_i > rpl_i) ? cpl_i : rpl_i;
    fault_o = eff_pl > dpl_i;
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_valid_i,
  input  logic [2:0]        ld_sreg_i,
  input  logic [15:0]       ld_sel_i,
  input  logic [31:0]       ld_base_i,
  input  logic [19:0]       ld_limit_i,
  input  logic              ld_gran_i,
  input  logic              ld_present_i,
  input  logic [1:0]        ld_dpl_i,
  input  logic              ld_dsize_i,
  input  logic              prot_mode_i,
  input  logic [1:0]        cpl_i,
  input  logic              req_valid_i,
  input  logic [2:0]        req_sreg_i,
  input  logic [31:0]       req_off_i,
  input  logic [1:0]        req_size_i,
  output logic              rsp_valid_o,
  output logic [31:0]       rsp_addr_o,
  output logic [1:0]        rsp_fault_o
);
  sreg_t             wr_data, cur;
  logic              cur_hit, lim_flt, priv_flt;
  logic [REAL_AW-1:0] real_sum;
  logic [ADDR_W-1:0] prot_sum, nxt_addr;
  fault_e            nxt_flt;

  assign wr_data = '{sel: ld_sel_i, base: ld_base_i, limit: ld_limit_i,
                     gran: ld_gran_i, present: ld_present_i,
                     dpl: ld_dpl_i, dsize: ld_dsize_i};

  seg_regfile u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (ld_valid_i),
    .wr_idx_i  (ld_sreg_i),
    .wr_data_i (wr_data),
    .rd_idx_i  (req_sreg_i),
    .rd_data_o (cur),
    .rd_hit_o  (cur_hit)
  );

  seg_limit_chk u_lim (
    .off_i   (req_off_i),
    .size_i  (req_size_i),
    .limit_i (cur.limit),
    .gran_i  (cur.gran),
    .dsize_i (cur.dsize),
    .fault_o (lim_flt)
  );

  seg_priv_chk u_priv (
    .cpl_i   (cpl_i),
    .rpl_i   (cur.sel[PL_W-1:0]),
    .dpl_i   (cur.dpl),
    .fault_o (priv_flt)
  );

  always_comb begin
    real_sum = {cur.sel, {REAL_SH{1'b0}}} + REAL_AW'(req_off_i[RM_OFF_W-1:0]);
    prot_sum = cur.base + req_off_i;
    if (!prot_mode_i)                 nxt_flt = FLT_NONE;
    else if (!cur_hit || !cur.present) nxt_flt = FLT_ABSENT;
    else if (priv_flt)                nxt_flt = FLT_PRIV;
    else if (lim_flt)                 nxt_flt = FLT_LIMIT;
    else                              nxt_flt = FLT_NONE;
    if (nxt_flt != FLT_NONE) nxt_addr = '0;
    else if (prot_mode_i)    nxt_addr = prot_sum;
    else                     nxt_addr = ADDR_W'(real_sum);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_addr_o  <= '0;
      rsp_fault_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_addr_o  <= req_valid_i ? nxt_addr : '0;
      rsp_fault_o <= req_valid_i ? nxt_flt : FLT_NONE;
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        prot_mode_i,
  input logic        req_valid_i,
  input logic        rsp_valid_o,
  input logic [31:0] rsp_addr_o,
  input logic [1:0]  rsp_fault_o
);
  a_r2_valid_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (rsp_addr_o == 32'd0 && rsp_fault_o == 2'd0));
  a_r3_real_no_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !prot_mode_i) |=> (rsp_fault_o == 2'd0));
  a_r3_real_20bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !prot_mode_i) |=> (rsp_addr_o[31:20] == 12'd0));
  a_r6_fault_zero_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_fault_o != 2'd0) |-> (rsp_addr_o == 32'd0));
endmodule

bind seg_xlate seg_xlate_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .prot_mode_i (prot_mode_i),
  .req_valid_i (req_valid_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_addr_o  (rsp_addr_o),
  .rsp_fault_o (rsp_fault_o)
);

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        ld_valid_i = 0;
  logic [2:0]  ld_sreg_i = 0;
  logic [15:0] ld_sel_i = 0;
  logic [31:0] ld_base_i = 0;
  logic [19:0] ld_limit_i = 0;
  logic        ld_gran_i = 0, ld_present_i = 0, ld_dsize_i = 0;
  logic [1:0]  ld_dpl_i = 0;
  logic        prot_mode_i = 0;
  logic [1:0]  cpl_i = 0;
  logic        req_valid_i = 0;
  logic [2:0]  req_sreg_i = 0;
  logic [31:0] req_off_i = 0;
  logic [1:0]  req_size_i = 0;
  logic        rsp_valid_o;
  logic [31:0] rsp_addr_o;
  logic [1:0]  rsp_fault_o;

  int checks = 0, errors = 0;
  bit done = 0;

  seg_xlate u_dut (.*);

  always #2 clk_i = ~clk_i;

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_real(input logic [15:0] sel, input logic [31:0] off);
    return (({16'd0, sel} << 4) + {16'd0, off[15:0]}) & 32'h000F_FFFF;
  endfunction

  task automatic load(input logic [2:0] idx, input logic [15:0] sel, input logic [31:0] base,
                      input logic [19:0] lim, input logic g, input logic p,
                      input logic [1:0] dpl, input logic ds);
    @(negedge clk_i);
    ld_valid_i = 1; ld_sreg_i = idx; ld_sel_i = sel; ld_base_i = base; ld_limit_i = lim;
    ld_gran_i = g; ld_present_i = p; ld_dpl_i = dpl; ld_dsize_i = ds;
    @(negedge clk_i);
    ld_valid_i = 0;
  endtask

  // drive at negedge, sample one clock later at the next negedge
  task automatic req(input logic prot, input logic [1:0] cpl, input logic [2:0] idx,
                     input logic [31:0] off, input logic [1:0] sz);
    @(negedge clk_i);
    prot_mode_i = prot; cpl_i = cpl; req_valid_i = 1; req_sreg_i = idx;
    req_off_i = off; req_size_i = sz;
    @(negedge clk_i);
    req_valid_i = 0;
  endtask

  task automatic expect_rsp(input string tag, input logic [31:0] addr, input logic [1:0] flt);
    chk({tag, " valid"}, {31'd0, rsp_valid_o}, 32'd1);
    chk({tag, " addr"}, rsp_addr_o, addr);
    chk({tag, " fault"}, {30'd0, rsp_fault_o}, {30'd0, flt});
  endtask

  task automatic t_reset;
    chk("R1 valid at reset", {31'd0, rsp_valid_o}, 32'd0);
    chk("R1 addr at reset", rsp_addr_o, 32'd0);
    chk("R1 fault at reset", {30'd0, rsp_fault_o}, 32'd0);
    for (int i = 0; i < 6; i++) begin
      req(1, 0, 3'(i), 32'h10, 0);
      expect_rsp("R1 empty reg absent", 32'd0, 2'd2);
    end
    req(0, 0, 0, 32'h1234, 0);
    expect_rsp("R1 reset selector zero", 32'h0000_1234, 2'd0);
  endtask

  task automatic t_idle;
    @(negedge clk_i);
    chk("R2 valid drops", {31'd0, rsp_valid_o}, 32'd0);
    chk("R2 idle addr zero", rsp_addr_o, 32'd0);
  endtask

  task automatic t_real;
    load(0, 16'h1100, 32'hDEAD_0000, 20'h0, 0, 0, 0, 0);
    req(0, 3, 0, 32'h0000_0450, 0);
    expect_rsp("R3 shift add", exp_real(16'h1100, 32'h450), 2'd0);
    req(0, 3, 0, 32'hABCD_0450, 3);
    expect_rsp("R3 upper offset ignored", 32'h0001_1450, 2'd0);
    load(1, 16'h1145, 32'h0, 20'h0, 0, 1, 0, 1);
    req(0, 0, 1, 32'h0, 0);
    expect_rsp("R4 alias", 32'h0001_1450, 2'd0);
    load(2, 16'hFFFF, 32'h0, 20'h0, 0, 1, 0, 1);
    req(0, 0, 2, 32'h10, 0);
    expect_rsp("R4 wrap to zero", 32'h0, 2'd0);
    req(0, 0, 2, 32'h20, 0);
    expect_rsp("R4 wrap", exp_real(16'hFFFF, 32'h20), 2'd0);
  endtask

  task automatic t_prot_g0;
    load(3, 16'h0008, 32'h1234_0000, 20'h00FFF, 0, 1, 0, 1);
    req(1, 0, 3, 32'h100, 3);
    expect_rsp("R5 base plus offset", 32'h1234_0100, 2'd0);
    req(1, 0, 3, 32'hFFC, 3);
    expect_rsp("R7 end on limit", 32'h1234_0FFC, 2'd0);
    req(1, 0, 3, 32'hFFD, 3);
    expect_rsp("R7 one past limit", 32'h0, 2'd1);
    req(1, 0, 3, 32'h1000, 0);
    expect_rsp("R7 byte past limit", 32'h0, 2'd1);
  endtask

  task automatic t_prot_g1;
    load(4, 16'h0010, 32'hFFFF_F000, 20'hFFFFF, 1, 1, 0, 1);
    req(1, 0, 4, 32'h2000, 0);
    expect_rsp("R5 base wrap", 32'h0000_1000, 2'd0);
    req(1, 0, 4, 32'hFFFF_FFFE, 3);
    expect_rsp("R8 wrap past 4GB", 32'h0, 2'd1);
    load(4, 16'h0010, 32'h0, 20'h00001, 1, 1, 0, 1);
    req(1, 0, 4, 32'h1FFF, 0);
    expect_rsp("R8 scaled limit edge", 32'h1FFF, 2'd0);
    req(1, 0, 4, 32'h1FFE, 3);
    expect_rsp("R8 scaled limit over", 32'h0, 2'd1);
  endtask

  task automatic t_dsize;
    load(5, 16'h0018, 32'h4000_0000, 20'hFFFFF, 1, 1, 0, 0);
    req(1, 0, 5, 32'hFFFE, 1);
    expect_rsp("R9 16-bit edge", 32'h4000_FFFE, 2'd0);
    req(1, 0, 5, 32'hFFFF, 1);
    expect_rsp("R9 16-bit over", 32'h0, 2'd1);
  endtask

  task automatic t_absent;
    load(2, 16'h0003, 32'h0, 20'h0, 0, 0, 0, 1);
    req(1, 3, 2, 32'hFFFF, 3);
    expect_rsp("R10 absent wins", 32'h0, 2'd2);
    req(1, 0, 6, 32'h0, 0);
    expect_rsp("R10 index 6", 32'h0, 2'd2);
    req(1, 0, 7, 32'h0, 0);
    expect_rsp("R10 index 7", 32'h0, 2'd2);
  endtask

  task automatic t_priv;
    load(3, 16'h000A, 32'h1000_0000, 20'h000FF, 0, 1, 2, 1);
    req(1, 0, 3, 32'h10, 0);
    expect_rsp("R11 rpl equals dpl", 32'h1000_0010, 2'd0);
    req(1, 3, 3, 32'h10, 0);
    expect_rsp("R11 cpl too low", 32'h0, 2'd3);
    load(3, 16'h000F, 32'h1000_0000, 20'h000FF, 0, 1, 2, 1);
    req(1, 0, 3, 32'h10, 0);
    expect_rsp("R11 rpl too low", 32'h0, 2'd3);
    req(1, 0, 3, 32'h200, 0);
    expect_rsp("R11 priv over limit", 32'h0, 2'd3);
  endtask

  task automatic t_load;
    load(6, 16'h2222, 32'h0, 20'h0, 0, 1, 3, 1);
    load(7, 16'h3333, 32'h0, 20'h0, 0, 1, 3, 1);
    req(0, 0, 0, 32'h450, 0);
    expect_rsp("R12 index 6/7 ignored", 32'h0001_1450, 2'd0);
    req(0, 0, 1, 32'h0, 0);
    expect_rsp("R12 neighbour unchanged", 32'h0001_1450, 2'd0);
    @(negedge clk_i);
    ld_valid_i = 1; ld_sreg_i = 0; ld_sel_i = 16'h2000; ld_base_i = 0; ld_limit_i = 0;
    ld_gran_i = 0; ld_present_i = 1; ld_dpl_i = 0; ld_dsize_i = 1;
    prot_mode_i = 0; req_valid_i = 1; req_sreg_i = 0; req_off_i = 32'h5; req_size_i = 0;
    @(negedge clk_i);
    ld_valid_i = 0; req_valid_i = 0;
    expect_rsp("R12 same-cycle old", 32'h0001_1005, 2'd0);
    req(0, 0, 0, 32'h5, 0);
    expect_rsp("R12 new value", 32'h0002_0005, 2'd0);
  endtask

  initial begin
    #1;
    t_reset_pre();
    rst_ni = 1'b1;
    t_reset;
    t_idle;
    t_real;
    t_prot_g0;
    t_prot_g1;
    t_dsize;
    t_absent;
    t_priv;
    t_load;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic t_reset_pre;
    repeat (3) @(negedge clk_i);
  endtask
endmodule